// File: doc/BRIEF.md
# Address-Space Tagged Translation Cache with Encoded Invalidation

This block is a small, fully associative cache of address translations. Every line carries an address-space tag, a 4 KiB virtual page number, a physical frame number and three permission flags (read, write, non-secure). A requester presents a tag and the upper twenty bits of a 32-bit virtual address. One cycle later the block returns hit or miss, together with the frame and the flags. After a miss, an external page walker installs the walked translation through the fill port.

Invalidation is driven by a 32-bit command word, not a single strobe. The two low bits pick the reach: the whole cache, one 4 MiB section or one 16 KiB group. The top bit limits the invalidation to one address space. The integration flushes everything once, before translation is enabled. A configuration input limits the number of lines in use, so that a smaller cache can be emulated.

Top module: `tlb_asid_cache`

## Requirements
- R1: A lookup presented in cycle t produces `rsp_valid_o` in cycle t+1. It hits only if some line is valid, lies inside the active line count, has a tag equal to the request tag and has a page number equal to virtual address bits [31:12]. On a hit it returns that line's frame and {read, write, non-secure} flags. On a miss the frame and the flags are all zero.
- R2: When no line matches the fill key, a fill writes the lowest-indexed invalid line inside the active count.
- R3: When every active line is valid, a fill replaces the line at a victim pointer. The pointer advances by one on every fill and wraps back to 0 at the active line count.
- R4: A fill whose tag and page number match an existing active line overwrites that line. A lookup therefore never matches more than one line.
- R5: Command bits [1:0] select the reach. 0 invalidates every line. 2 invalidates lines whose page bits [19:10] (virtual address bits [31:22]) equal command bits [19:10]. 3 invalidates lines whose page bits [19:2] (virtual address bits [31:14]) equal command bits [19:2].
- R6: When command bit 31 is set, only lines whose tag equals the command tag field are invalidated. With a 7-bit tag the field is bits [30:24]. With the 2-bit tag variant it is bits [30:29].
- R7: A command with bits [1:0] equal to 1 has no effect on any line.
- R8: A flush takes effect before a lookup in the same cycle, so such a lookup misses on every line that the flush invalidates.
- R9: Lines at or above `cfg_lines_i` are ignored by lookups and fills but keep their contents. A value of 0, or a value above the line count, enables all lines.
- R10: After reset every line is invalid and `rsp_valid_o` and `rsp_hit_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_lines_i | input | $clog2(ENTRIES+1) | Number of active lines (0 = all) |
| lk_valid_i | input | 1 | Lookup request |
| lk_asid_i | input | ASID_W | Lookup address-space tag |
| lk_va_i | input | 20 | Lookup virtual address bits [31:12] |
| fill_i | input | 1 | Install a translation |
| fill_asid_i | input | ASID_W | Fill address-space tag |
| fill_vpn_i | input | 20 | Fill virtual page number |
| fill_pfn_i | input | PFN_W | Fill physical frame number |
| fill_rd_i | input | 1 | Fill read permission |
| fill_wr_i | input | 1 | Fill write permission |
| fill_ns_i | input | 1 | Fill non-secure flag |
| flush_i | input | 1 | Flush command strobe |
| flush_cmd_i | input | 32 | Encoded flush command |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_pfn_o | output | PFN_W | Frame of the hit line |
| rsp_rd_o | output | 1 | Read permission of the hit line |
| rsp_wr_o | output | 1 | Write permission of the hit line |
| rsp_ns_o | output | 1 | Non-secure flag of the hit line |

## Verification
A wrong valid bit or a wrong victim choice appears on the very next lookup of the affected page, one cycle after it is presented. The result is a hit where a miss is due, or a frame from an evicted translation. A flush comparison on the wrong field shows up as survivors in the group, the section or the tag that should have been cleared, or as losses outside them. The bench probes lookups on both sides of each of these boundaries. A duplicate line would OR two frames together and corrupt the returned frame at once.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W    = 32;
  localparam int PAGE_SH = 12;
  localparam int VPN_W   = VA_W - PAGE_SH;

  typedef enum logic [1:0] {
    FL_ALL  = 2'd0,
    FL_RSVD = 2'd1,
    FL_SECT = 2'd2,
    FL_GRP  = 2'd3
  } flush_kind_e;
endpackage

// File: rtl/tlb_flush_dec.sv
module tlb_flush_dec #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 7,
  parameter int VPN_W   = 20
) (
  input  logic                           flush_i,
  input  logic [31:0]                    cmd_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  output logic [ENTRIES-1:0]             kill_o
);
  import tlb_pkg::*;

  localparam int ASID_LSB = (ASID_W == 2) ? 29 : 31 - ASID_W;

  flush_kind_e       kind;
  logic              asid_en;
  logic [ASID_W-1:0] cmd_asid;
  logic              unused_cmd;

  assign kind       = flush_kind_e'(cmd_i[1:0]);
  assign asid_en    = cmd_i[31];
  assign cmd_asid   = cmd_i[ASID_LSB +: ASID_W];
  assign unused_cmd = ^cmd_i[23:20];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic addr_hit;
    always_comb begin
      unique case (kind)
        FL_ALL:  addr_hit = 1'b1;
        FL_SECT: addr_hit = (vpn_i[g][19:10] == cmd_i[19:10]);
        FL_GRP:  addr_hit = (vpn_i[g][19:2]  == cmd_i[19:2]);
        default: addr_hit = 1'b0;
      endcase
    end
    assign kill_o[g] = flush_i & addr_hit & (~asid_en | (asid_i[g] == cmd_asid));
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 7,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]             en_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0]              key_asid_i,
  input  logic [VPN_W-1:0]               key_vpn_i,
  output logic [ENTRIES-1:0]             hit_vec_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = en_i[g] & (asid_i[g] == key_asid_i) & (vpn_i[g] == key_vpn_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINE_W = $clog2(ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic [LINE_W-1:0]  lines_i,
  input  logic [ENTRIES-1:0] act_i,
  input  logic [ENTRIES-1:0] live_i,
  input  logic [ENTRIES-1:0] dup_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] ptr_q, base, free_idx, dup_idx;
  logic             free_any, dup_any;

  always_comb begin
    base     = (LINE_W'(ptr_q) >= lines_i) ? '0 : ptr_q;
    free_idx = '0;
    free_any = 1'b0;
    dup_idx  = '0;
    dup_any  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (act_i[i] && !live_i[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
      if (dup_i[i]) begin
        dup_idx = IDX_W'(i);
        dup_any = 1'b1;
      end
    end
    idx_o = dup_any ? dup_idx : (free_any ? free_idx : base);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ((LINE_W'(base) + LINE_W'(1)) >= lines_i) ? '0 : base + IDX_W'(1);
  end
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 7,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINE_W = $clog2(ENTRIES + 1),
  localparam int VPN_W  = tlb_pkg::VPN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] cfg_lines_i,
  input  logic              lk_valid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  lk_va_i,
  input  logic              fill_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_rd_i,
  input  logic              fill_wr_i,
  input  logic              fill_ns_i,
  input  logic              flush_i,
  input  logic [31:0]       flush_cmd_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [PFN_W-1:0]  rsp_pfn_o,
  output logic              rsp_rd_o,
  output logic              rsp_wr_o,
  output logic              rsp_ns_o
);
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][2:0]        perm_q;

  logic [LINE_W-1:0]  lines;
  logic [ENTRIES-1:0] act, live, kill, look_en, lk_vec, dup_vec;
  logic [IDX_W-1:0]   fill_idx;
  logic [PFN_W-1:0]   pfn_mux;
  logic [2:0]         perm_mux;

  assign lines = (cfg_lines_i == '0 || int'(cfg_lines_i) > ENTRIES) ? LINE_W'(ENTRIES) : cfg_lines_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_act
    assign act[g] = (int'(lines) > g);
  end

  assign live    = valid_q & act;
  assign look_en = live & ~kill;

  tlb_flush_dec #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) i_flush (
    .flush_i (flush_i),
    .cmd_i   (flush_cmd_i),
    .asid_i  (asid_q),
    .vpn_i   (vpn_q),
    .kill_o  (kill)
  );

  tlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) i_look (
    .en_i       (look_en),
    .asid_i     (asid_q),
    .vpn_i      (vpn_q),
    .key_asid_i (lk_asid_i),
    .key_vpn_i  (lk_va_i),
    .hit_vec_o  (lk_vec)
  );

  tlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) i_dup (
    .en_i       (live),
    .asid_i     (asid_q),
    .vpn_i      (vpn_q),
    .key_asid_i (fill_asid_i),
    .key_vpn_i  (fill_vpn_i),
    .hit_vec_o  (dup_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (fill_i),
    .lines_i (lines),
    .act_i   (act),
    .live_i  (live),
    .dup_i   (dup_vec),
    .idx_o   (fill_idx)
  );

  // flush clears first; a same-cycle fill still lands
  always_comb begin
    valid_d = valid_q & ~kill;
    if (fill_i) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      asid_q[fill_idx] <= fill_asid_i;
      vpn_q[fill_idx]  <= fill_vpn_i;
      pfn_q[fill_idx]  <= fill_pfn_i;
      perm_q[fill_idx] <= {fill_rd_i, fill_wr_i, fill_ns_i};
    end
  end

  always_comb begin
    pfn_mux  = '0;
    perm_mux = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_vec[e]) begin
        pfn_mux  = pfn_mux | pfn_q[e];
        perm_mux = perm_mux | perm_q[e];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_pfn_o   <= '0;
      {rsp_rd_o, rsp_wr_o, rsp_ns_o} <= '0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= lk_valid_i & (|lk_vec);
      rsp_pfn_o   <= lk_valid_i ? pfn_mux : '0;
      {rsp_rd_o, rsp_wr_o, rsp_ns_o} <= lk_valid_i ? perm_mux : 3'b000;
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int PFN_W   = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic [1:0]         cmd_kind_i,
  input logic               cmd_asid_en_i,
  input logic               fill_i,
  input logic               lk_valid_i,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic [PFN_W-1:0]   rsp_pfn_o,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lk_vec
);
  // R1
  hit_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);

  // R1
  miss_zero_pfn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_pfn_o == '0));

  // R1
  rsp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);

  // R4
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec));

  // R5
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && cmd_kind_i == 2'd0 && !cmd_asid_en_i && !fill_i) |=> (valid_q == '0));

  // R7
  rsvd_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && cmd_kind_i == 2'd1 && !fill_i) |=> (valid_q == $past(valid_q)));
endmodule

bind tlb_asid_cache tlb_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .cmd_kind_i    (flush_cmd_i[1:0]),
  .cmd_asid_en_i (flush_cmd_i[31]),
  .fill_i        (fill_i),
  .lk_valid_i    (lk_valid_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_hit_o     (rsp_hit_o),
  .rsp_pfn_o     (rsp_pfn_o),
  .valid_q       (valid_q),
  .lk_vec        (lk_vec)
);

// File: tb/test_tlb_asid_cache.sv
module test_tlb_asid_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]  cfg_lines = '0;
  logic        lk_valid = 0, fill = 0, fill_rd = 0, fill_wr = 0, fill_ns = 0, flush = 0;
  logic [6:0]  lk_asid = '0, fill_asid = '0;
  logic [19:0] lk_va = '0, fill_vpn = '0, fill_pfn = '0;
  logic [31:0] flush_cmd = '0;
  logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ns;
  logic [19:0] rsp_pfn;

  tlb_asid_cache i_tlb_asid_cache (
    .clk_i(clk), .rst_ni(rst_n), .cfg_lines_i(cfg_lines),
    .lk_valid_i(lk_valid), .lk_asid_i(lk_asid), .lk_va_i(lk_va),
    .fill_i(fill), .fill_asid_i(fill_asid), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
    .fill_rd_i(fill_rd), .fill_wr_i(fill_wr), .fill_ns_i(fill_ns),
    .flush_i(flush), .flush_cmd_i(flush_cmd),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_pfn_o(rsp_pfn),
    .rsp_rd_o(rsp_rd), .rsp_wr_o(rsp_wr), .rsp_ns_o(rsp_ns)
  );

  // narrow-tag variant
  logic        n_lk_valid = 0, n_fill = 0, n_flush = 0;
  logic [1:0]  n_lk_asid = '0, n_fill_asid = '0;
  logic [19:0] n_lk_va = '0, n_fill_vpn = '0;
  logic [31:0] n_cmd = '0;
  logic        n_rsp_valid, n_rsp_hit, n_rd, n_wr, n_ns;
  logic [19:0] n_pfn;

  tlb_asid_cache #(.ENTRIES(4), .ASID_W(2), .PFN_W(20)) i_tlb_asid_cache_narrow (
    .clk_i(clk), .rst_ni(rst_n), .cfg_lines_i(3'd0),
    .lk_valid_i(n_lk_valid), .lk_asid_i(n_lk_asid), .lk_va_i(n_lk_va),
    .fill_i(n_fill), .fill_asid_i(n_fill_asid), .fill_vpn_i(n_fill_vpn), .fill_pfn_i(20'h00777),
    .fill_rd_i(1'b1), .fill_wr_i(1'b0), .fill_ns_i(1'b1),
    .flush_i(n_flush), .flush_cmd_i(n_cmd),
    .rsp_valid_o(n_rsp_valid), .rsp_hit_o(n_rsp_hit), .rsp_pfn_o(n_pfn),
    .rsp_rd_o(n_rd), .rsp_wr_o(n_wr), .rsp_ns_o(n_ns)
  );

  typedef struct {
    logic        hit;
    logic [19:0] pfn;
    logic [2:0]  perm;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) chk(1'b0, "R1 unexpected response", 32'd1, 32'd0);
      else begin
        e = q.pop_front();
        chk(rsp_hit == e.hit, {e.tag, " hit"}, {31'd0, rsp_hit}, {31'd0, e.hit});
        chk(rsp_pfn == e.pfn, {e.tag, " pfn"}, {12'd0, rsp_pfn}, {12'd0, e.pfn});
        chk({rsp_rd, rsp_wr, rsp_ns} == e.perm, {e.tag, " perm"},
            {29'd0, rsp_rd, rsp_wr, rsp_ns}, {29'd0, e.perm});
      end
    end
  end

  task automatic look(input logic [6:0] a, input logic [19:0] va, input logic eh,
                      input logic [19:0] ep, input logic [2:0] eperm, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_asid = a; lk_va = va;
    q.push_back('{eh, eh ? ep : 20'd0, eh ? eperm : 3'd0, tag});
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic put(input logic [6:0] a, input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] perm);
    @(negedge clk);
    fill = 1; fill_asid = a; fill_vpn = vpn; fill_pfn = pfn; {fill_rd, fill_wr, fill_ns} = perm;
    @(negedge clk);
    fill = 0;
  endtask

  task automatic fl(input logic [31:0] cmd);
    @(negedge clk);
    flush = 1; flush_cmd = cmd;
    @(negedge clk);
    flush = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10
    chk(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R10 reset outputs", {30'd0, rsp_valid, rsp_hit}, 32'd0);
    rst_n = 1'b1;
    cfg_lines = 4'd8;
    look(7'd1, 20'h00100, 1'b0, 20'd0, 3'd0, "R10 empty after reset");

    // R2 / R1: fill eight lines into an empty cache
    for (int i = 0; i < 8; i++) put(7'd1, 20'h00100 + 20'(i), 20'h00500 + 20'(i), 3'(i));
    for (int i = 0; i < 8; i++) look(7'd1, 20'h00100 + 20'(i), 1'b1, 20'h00500 + 20'(i), 3'(i), "R1 hit after fill");
    look(7'd2, 20'h00101, 1'b0, 20'd0, 3'd0, "R1 tag mismatch");

    // R3: full, pointer at 0 after eight fills
    put(7'd1, 20'h00200, 20'h00AAA, 3'b101);
    look(7'd1, 20'h00100, 1'b0, 20'd0, 3'd0, "R3 first victim evicted");
    look(7'd1, 20'h00200, 1'b1, 20'h00AAA, 3'b101, "R3 new line hit");
    look(7'd1, 20'h00101, 1'b1, 20'h00501, 3'd1, "R3 neighbour kept");

    // R4: refill of an existing key overwrites it (pointer moves to 2)
    put(7'd1, 20'h00101, 20'h00BBB, 3'b111);
    look(7'd1, 20'h00101, 1'b1, 20'h00BBB, 3'b111, "R4 overwrite");
    put(7'd1, 20'h00201, 20'h00CCC, 3'b010);
    look(7'd1, 20'h00102, 1'b0, 20'd0, 3'd0, "R3 pointer advanced");
    look(7'd1, 20'h00201, 1'b1, 20'h00CCC, 3'b010, "R3 second victim hit");

    // R5: global flush
    fl(32'h0000_0000);
    look(7'd1, 20'h00103, 1'b0, 20'd0, 3'd0, "R5 global flush");
    look(7'd1, 20'h00200, 1'b0, 20'd0, 3'd0, "R5 global flush");

    // R5 / R6: group flush qualified by tag 1
    put(7'd1, 20'h00400, 20'h00010, 3'b100);
    put(7'd1, 20'h00401, 20'h00011, 3'b100);
    put(7'd1, 20'h00404, 20'h00012, 3'b100);
    put(7'd1, 20'h00800, 20'h00013, 3'b100);
    put(7'd2, 20'h00400, 20'h00014, 3'b100);
    fl(32'h8100_0403);
    look(7'd1, 20'h00400, 1'b0, 20'd0, 3'd0, "R5 group flushed");
    look(7'd1, 20'h00401, 1'b0, 20'd0, 3'd0, "R5 group flushed");
    look(7'd1, 20'h00404, 1'b1, 20'h00012, 3'b100, "R5 other group kept");
    look(7'd1, 20'h00800, 1'b1, 20'h00013, 3'b100, "R5 other section kept");
    look(7'd2, 20'h00400, 1'b1, 20'h00014, 3'b100, "R6 other tag kept");

    // R5: section flush, no tag qualifier
    fl(32'h0000_0402);
    look(7'd1, 20'h00404, 1'b0, 20'd0, 3'd0, "R5 section flushed");
    look(7'd2, 20'h00400, 1'b0, 20'd0, 3'd0, "R5 section flushed any tag");
    look(7'd1, 20'h00800, 1'b1, 20'h00013, 3'b100, "R5 section outside kept");

    // R6: tag-only flush
    put(7'd2, 20'h00900, 20'h00020, 3'b011);
    fl(32'h8100_0000);
    look(7'd1, 20'h00800, 1'b0, 20'd0, 3'd0, "R6 tag flush");
    look(7'd2, 20'h00900, 1'b1, 20'h00020, 3'b011, "R6 tag flush spares other");

    // R7: reserved kind
    fl(32'h0000_0001);
    look(7'd2, 20'h00900, 1'b1, 20'h00020, 3'b011, "R7 reserved no effect");

    // R8: flush and lookup together
    @(negedge clk);
    flush = 1; flush_cmd = 32'h0; lk_valid = 1; lk_asid = 7'd2; lk_va = 20'h00900;
    q.push_back('{1'b0, 20'd0, 3'd0, "R8 flush before lookup"});
    @(negedge clk);
    flush = 0; lk_valid = 0;
    look(7'd2, 20'h00900, 1'b0, 20'd0, 3'd0, "R8 stays flushed");

    // R9 / R2: active line limit hides upper lines
    put(7'd3, 20'h00B00, 20'h00030, 3'b001);
    put(7'd3, 20'h00B01, 20'h00031, 3'b001);
    put(7'd3, 20'h00B02, 20'h00032, 3'b001);
    @(negedge clk); cfg_lines = 4'd2;
    look(7'd3, 20'h00B02, 1'b0, 20'd0, 3'd0, "R9 line above limit ignored");
    look(7'd3, 20'h00B00, 1'b1, 20'h00030, 3'b001, "R2 lowest line used");
    @(negedge clk); cfg_lines = 4'd0;
    look(7'd3, 20'h00B02, 1'b1, 20'h00032, 3'b001, "R9 hidden line kept");

    // R6: narrow-tag field at [30:29]
    @(negedge clk); n_fill = 1; n_fill_asid = 2'd1; n_fill_vpn = 20'h00010;
    @(negedge clk); n_fill_asid = 2'd2;
    @(negedge clk); n_fill = 0; n_flush = 1; n_cmd = 32'hA000_0000;
    @(negedge clk); n_flush = 0; n_lk_valid = 1; n_lk_asid = 2'd1; n_lk_va = 20'h00010;
    @(negedge clk); n_lk_asid = 2'd2;
    chk(n_rsp_valid && !n_rsp_hit, "R6 narrow tag flushed", {31'd0, n_rsp_hit}, 32'd0);
    @(negedge clk); n_lk_valid = 0;
    chk(n_rsp_valid && n_rsp_hit && n_pfn == 20'h00777, "R6 narrow other tag kept",
        {11'd0, n_rsp_hit, n_pfn}, {11'd1, 20'h00777});

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1 all responses seen", q.size(), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule